// File: doc/BRIEF.md
# Coprocessor-0 Exception Response Unit

This block holds the three system registers a simple in-order core needs to take and leave a precise exception: a saved program counter (EPC), a status word (Status) and a reason word (Cause). When the pipeline raises an exception request with a 5-bit reason code and the address of the offending instruction, the unit redirects fetch to a fixed entry vector at 0x80000180 in the same cycle. At the next clock edge it stores the address in EPC, places the code in Cause and sets the exception-level flag in Status, which puts the core in kernel mode.

A return request redirects fetch to the address held in EPC and clears the exception-level flag. Software reads the registers through a move-from port and writes them through a move-to port. A trap handler for a system call reads EPC, adds 4 and writes it back, so that the return resumes after the trap instruction rather than repeating it. The select code is 0 for EPC, 1 for Status and 2 for Cause. Select 3 is unmapped.

Top module: `cp0_exc_unit`

## Requirements
- R1: While exc_req_i is high, redirect_o is high and redirect_pc_o equals 0x80000180 in the same cycle.
- R2: At the clock edge that ends an exception cycle, EPC takes the value of exc_pc_i.
- R3: At that edge, Cause bits 6..2 take exc_code_i and every other Cause bit keeps its value.
- R4: At that edge, Status bit 1 (the exception-level flag) is set and kernel_mode_o goes high. Every other Status bit keeps its value.
- R5: While ret_req_i is high and exc_req_i is low, redirect_o is high and redirect_pc_o equals the current EPC. At the following edge, Status bit 1 clears and the other Status bits keep their values.
- R6: When exc_req_i and ret_req_i are both high in one cycle, the exception wins: the vector is 0x80000180, EPC and Cause are updated, and Status bit 1 ends up set.
- R7: A move-to write with select 0, 1 or 2 stores all 32 bits into EPC, Status or Cause respectively. The move-from port shows the selected register combinationally. Select 3 is not written and reads as zero.
- R8: Status bits other than bit 1 are plain storage: they read back exactly as written and have no side effects.
- R9: A move-to write issued in the same cycle as an exception or a return is dropped.
- R10: After reset, EPC, Status and Cause are zero, redirect_o is low and kernel_mode_o is low. With no request pending, redirect_o stays low.
- R11: A value written into EPC by software is the address used by the next return, which allows the add-4 fixup after a system-call trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_req_i | input | 1 | Exception request |
| exc_code_i | input | 5 | Exception reason code |
| exc_pc_i | input | 32 | Address of the excepting instruction |
| ret_req_i | input | 1 | Exception-return request |
| mt_en_i | input | 1 | Move-to write enable |
| mt_sel_i | input | 2 | Move-to register select (0 EPC, 1 Status, 2 Cause) |
| mt_data_i | input | 32 | Move-to write data |
| mf_sel_i | input | 2 | Move-from register select |
| mf_data_o | output | 32 | Move-from read data |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| kernel_mode_o | output | 1 | Exception-level flag from Status |

## Verification
The hardest situation to produce is a collision: an exception, a return and a software write all landing in the same cycle, because the arbitration outcome only shows up one edge later as register contents. The bench drives these overlaps on purpose. It raises an exception and a return together with a non-zero code whose Cause bits differ from the stored ones. It also pairs a move-to write with an exception and with a return. The bench then reads EPC, Status and Cause back through the move-from port, so that a dropped write and a partial field update can each be told apart from a correct result.

// File: rtl/cp0_pkg.sv
package cp0_pkg;
  typedef enum logic [1:0] {
    SEL_EPC    = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CAUSE  = 2'd2,
    SEL_NONE   = 2'd3
  } cp0_sel_e;

  typedef enum logic [1:0] {
    EV_IDLE   = 2'd0,
    EV_TRAP   = 2'd1,
    EV_RETURN = 2'd2,
    EV_WRITE  = 2'd3
  } cp0_event_e;
endpackage

// File: rtl/cp0_event_arb.sv
module cp0_event_arb
  import cp0_pkg::*;
(
  input  logic       exc_i,
  input  logic       ret_i,
  input  logic       wr_i,
  output cp0_event_e ev_o
);
  // fixed priority: trap > return > software write
  always_comb begin
    if (exc_i)      ev_o = EV_TRAP;
    else if (ret_i) ev_o = EV_RETURN;
    else if (wr_i)  ev_o = EV_WRITE;
    else            ev_o = EV_IDLE;
  end

  always_comb begin
    if (wr_i && (exc_i || ret_i))
      AST_WRITE_DROPPED: assert (ev_o != EV_WRITE); // R9
  end
endmodule

// File: rtl/cp0_sysreg_file.sv
module cp0_sysreg_file
  import cp0_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 5,
  parameter int CODE_LSB = 2,
  parameter int EXL_BIT  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cp0_event_e       ev_i,
  input  logic [XLEN-1:0]  exc_pc_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  cp0_sel_e         wr_sel_i,
  input  logic [XLEN-1:0]  wr_data_i,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  cause_o
);
  localparam logic [XLEN-1:0] EXL_MASK  = XLEN'(1) << EXL_BIT;
  localparam logic [XLEN-1:0] CODE_MASK = ((XLEN'(1) << CODE_W) - XLEN'(1)) << CODE_LSB;

  logic [XLEN-1:0] epc_q, status_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q    <= '0;
      status_q <= '0;
      cause_q  <= '0;
    end else begin
      unique case (ev_i)
        EV_TRAP: begin
          epc_q    <= exc_pc_i;
          status_q <= status_q | EXL_MASK;
          cause_q  <= (cause_q & ~CODE_MASK) | (XLEN'(exc_code_i) << CODE_LSB);
        end
        EV_RETURN: status_q <= status_q & ~EXL_MASK;
        EV_WRITE: begin
          case (wr_sel_i)
            SEL_EPC:    epc_q    <= wr_data_i;
            SEL_STATUS: status_q <= wr_data_i;
            SEL_CAUSE:  cause_q  <= wr_data_i;
            default:    ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign epc_o    = epc_q;
  assign status_o = status_q;
  assign cause_o  = cause_q;

  AST_TRAP_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_TRAP |=> epc_q == $past(exc_pc_i)); // R2
  AST_TRAP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_TRAP |=> cause_q[CODE_LSB+CODE_W-1:CODE_LSB] == $past(exc_code_i)); // R3
  AST_TRAP_CAUSE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_TRAP |=> (cause_q & ~CODE_MASK) == ($past(cause_q) & ~CODE_MASK)); // R3
  AST_TRAP_EXL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_TRAP |=> status_q[EXL_BIT] && ((status_q & ~EXL_MASK) == ($past(status_q) & ~EXL_MASK))); // R4
  AST_RET_EXL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i == EV_RETURN |=> !status_q[EXL_BIT] && $stable(epc_q) && $stable(cause_q)); // R5
endmodule

// File: rtl/cp0_read_mux.sv
module cp0_read_mux
  import cp0_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cp0_sel_e        sel_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] cause_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    case (sel_i)
      SEL_EPC:    data_o = epc_i;
      SEL_STATUS: data_o = status_i;
      SEL_CAUSE:  data_o = cause_i;
      default:    data_o = '0;
    endcase
  end
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
  import cp0_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 5,
  parameter int              CODE_LSB = 2,
  parameter int              EXL_BIT  = 1,
  parameter logic [XLEN-1:0] VECTOR   = 32'h8000_0180
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   exc_pc_i,
  input  logic              ret_req_i,
  input  logic              mt_en_i,
  input  logic [1:0]        mt_sel_i,
  input  logic [XLEN-1:0]   mt_data_i,
  input  logic [1:0]        mf_sel_i,
  output logic [XLEN-1:0]   mf_data_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              kernel_mode_o
);
  cp0_event_e      ev;
  logic [XLEN-1:0] epc, status, cause;

  cp0_event_arb u_arb (
    .exc_i (exc_req_i),
    .ret_i (ret_req_i),
    .wr_i  (mt_en_i),
    .ev_o  (ev)
  );

  cp0_sysreg_file #(
    .XLEN(XLEN), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB), .EXL_BIT(EXL_BIT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .exc_pc_i   (exc_pc_i),
    .exc_code_i (exc_code_i),
    .wr_sel_i   (cp0_sel_e'(mt_sel_i)),
    .wr_data_i  (mt_data_i),
    .epc_o      (epc),
    .status_o   (status),
    .cause_o    (cause)
  );

  cp0_read_mux #(.XLEN(XLEN)) u_rd (
    .sel_i    (cp0_sel_e'(mf_sel_i)),
    .epc_i    (epc),
    .status_i (status),
    .cause_i  (cause),
    .data_o   (mf_data_o)
  );

  assign redirect_o    = (ev == EV_TRAP) || (ev == EV_RETURN);
  assign redirect_pc_o = (ev == EV_TRAP) ? VECTOR : epc;
  assign kernel_mode_o = status[EXL_BIT];

  AST_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |-> redirect_o && redirect_pc_o == VECTOR); // R1
  AST_RET_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && !exc_req_i |-> redirect_o && redirect_pc_o == epc); // R5
  AST_COLLIDE_KERNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && ret_req_i |=> kernel_mode_o); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_i && !ret_req_i |-> !redirect_o); // R10
endmodule

// File: tb/cp0_exc_unit_test.sv
module cp0_exc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        ret_req = 1'b0;
  logic        mt_en = 1'b0;
  logic [1:0]  mt_sel = '0;
  logic [31:0] mt_data = '0;
  logic [1:0]  mf_sel = '0;
  logic [31:0] mf_data;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        kernel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] VEC = 32'h8000_0180;

  always #10 clk = ~clk;

  cp0_exc_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_req_i(exc_req), .exc_code_i(exc_code), .exc_pc_i(exc_pc),
    .ret_req_i(ret_req),
    .mt_en_i(mt_en), .mt_sel_i(mt_sel), .mt_data_i(mt_data),
    .mf_sel_i(mf_sel), .mf_data_o(mf_data),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc), .kernel_mode_o(kernel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    exc_req = 0; ret_req = 0; mt_en = 0;
  endtask

  // inputs change on negedge; registers observed one negedge after posedge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    mf_sel = sel; #1; v = mf_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    mt_en = 1; mt_sel = sel; mt_data = d;
    step(); idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R10 epc", v, 32'h0);
    rd(2'd1, v); chk("R10 status", v, 32'h0);
    rd(2'd2, v); chk("R10 cause", v, 32'h0);
    chk("R10 redirect", {31'b0, redirect}, 32'h0);
    chk("R10 kernel", {31'b0, kernel}, 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] v;
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'hA5A5_A5A4);
    wr(2'd2, 32'h0000_FF00);
    rd(2'd0, v); chk("R7 epc", v, 32'h1234_5678);
    rd(2'd1, v); chk("R8 status", v, 32'hA5A5_A5A4);
    rd(2'd2, v); chk("R7 cause", v, 32'h0000_FF00);
    chk("R8 kernel unaffected", {31'b0, kernel}, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R7 sel3 read", v, 32'h0);
    rd(2'd0, v); chk("R7 sel3 epc kept", v, 32'h1234_5678);
    rd(2'd1, v); chk("R7 sel3 status kept", v, 32'hA5A5_A5A4);
    rd(2'd2, v); chk("R7 sel3 cause kept", v, 32'h0000_FF00);
    chk("R10 idle redirect", {31'b0, redirect}, 32'h0);
  endtask

  task automatic t_exception();
    logic [31:0] v;
    exc_req = 1; exc_code = 5'd8; exc_pc = 32'h0040_1000; #1;
    chk("R1 redirect", {31'b0, redirect}, 32'h1);
    chk("R1 vector", redirect_pc, VEC);
    step(); idle();
    rd(2'd0, v); chk("R2 epc", v, 32'h0040_1000);
    rd(2'd2, v); chk("R3 cause", v, 32'h0000_FF20);
    rd(2'd1, v); chk("R4 status", v, 32'hA5A5_A5A6);
    chk("R4 kernel", {31'b0, kernel}, 32'h1);
  endtask

  task automatic t_syscall_return();
    logic [31:0] v;
    rd(2'd0, v);
    wr(2'd0, v + 32'd4);
    ret_req = 1; #1;
    chk("R5 redirect", {31'b0, redirect}, 32'h1);
    chk("R11 return target", redirect_pc, 32'h0040_1004);
    step(); idle();
    rd(2'd1, v); chk("R5 status", v, 32'hA5A5_A5A4);
    chk("R5 kernel", {31'b0, kernel}, 32'h0);
    rd(2'd0, v); chk("R5 epc kept", v, 32'h0040_1004);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    exc_req = 1; ret_req = 1; exc_code = 5'h1F; exc_pc = 32'h0050_0000; #1;
    chk("R6 vector", redirect_pc, VEC);
    step(); idle();
    chk("R6 kernel", {31'b0, kernel}, 32'h1);
    rd(2'd0, v); chk("R6 epc", v, 32'h0050_0000);
    rd(2'd2, v); chk("R6 cause", v, 32'h0000_FF7C);
  endtask

  task automatic t_write_drop();
    logic [31:0] v;
    exc_req = 1; exc_code = 5'd0; exc_pc = 32'h0060_0000;
    mt_en = 1; mt_sel = 2'd0; mt_data = 32'hDEAD_0000;
    step(); idle();
    rd(2'd0, v); chk("R9 epc on trap", v, 32'h0060_0000);
    rd(2'd2, v); chk("R3 cause code zero", v, 32'h0000_FF00);
    ret_req = 1; mt_en = 1; mt_sel = 2'd1; mt_data = 32'h0;
    step(); idle();
    rd(2'd1, v); chk("R9 status on return", v, 32'hA5A5_A5A4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_exception();
    t_syscall_return();
    t_collision();
    t_write_drop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule